// File: doc/BRIEF.md
# Host Command Register Interface

This block sits between a host processor bus and the controller core of a disk controller. The host sees four byte-wide registers behind one address bit. Two are write-only: the command register and the parameter register. Two are read-only: the status register and the result register. A select line, a read strobe and a write strobe complete the bus.

The block keeps five handshake flags: command busy, command full, parameter full, result full and interrupt. The controller core consumes these flags through a small strobe interface. A pop strobe takes the pending command, a second pop strobe takes the pending parameter, a load strobe posts a result byte, and a seek-start strobe releases the busy flag early so that seeks can overlap.

Each host access takes effect once, on the first clock cycle in which its strobe is seen together with select. A command written while the block is busy is dropped, and a sticky protocol-error flag is raised toward the core.

Top module: `host_cmd_regs`

## Requirements
- R1: Address 1 selects the control pair: a read returns status and a write loads the command. Address 0 selects the data pair: a read returns the result and a write loads the parameter. Read data is combinational from `sel`, `rd` and `addr`.
- R2: A command write accepted while busy is 0 sets command busy and command full on the next clock, and presents the byte on `cmd_byte`.
- R3: A `cmd_pop` clears command full. Command busy stays set.
- R4: A parameter write while parameter full is 0 sets parameter full and presents the byte on `prm_byte`. A `prm_pop` clears the flag. A parameter write while the flag is set is dropped, and `prm_byte` keeps its earlier value.
- R5: A `res_load` latches `res_byte` into the result register and sets result full and interrupt. The `irq` output equals the interrupt bit.
- R6: A host read of the result register clears interrupt, result full and command busy.
- R7: A `seek_start` clears command busy. A later `res_load` sets result full and interrupt but leaves busy at 0.
- R8: A command write while busy is dropped. The command byte and the flags are unchanged, and the sticky `proto_err` output goes to 1. Only reset clears it.
- R9: Reset clears the command, parameter and result registers, all five flags and `proto_err`.
- R10: The status byte has busy at bit 7, command full at bit 6, parameter full at bit 5, result full at bit 4 and interrupt at bit 3. Bits 2 to 0 read as 0.
- R11: A strobe held over several cycles counts as one access. A result read that stays asserted does not clear a result loaded after its first cycle.
- R12: If `res_load` and the first cycle of a result read fall in the same clock, the new result wins. Result full and interrupt end up set, and busy is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Host register select |
| addr | input | 1 | Register address (1 = status/command, 0 = result/parameter) |
| rd | input | 1 | Host read strobe |
| wr | input | 1 | Host write strobe |
| din | input | DATA_W | Host write data |
| dout | output | DATA_W | Host read data |
| irq | output | 1 | Interrupt request to host |
| cmd_valid | output | 1 | Command full, seen by the core |
| cmd_byte | output | DATA_W | Latched command byte |
| cmd_pop | input | 1 | Core takes the command |
| prm_valid | output | 1 | Parameter full, seen by the core |
| prm_byte | output | DATA_W | Latched parameter byte |
| prm_pop | input | 1 | Core takes the parameter |
| res_load | input | 1 | Core posts a result |
| res_byte | input | DATA_W | Result byte from the core |
| seek_start | input | 1 | Core has started a seek; releases busy |
| busy | output | 1 | Command busy flag |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with its default byte width of 8, so that the status layout of R10 can be compared bit for bit. With that width, one status read shows every flag at once, and each step of the command, parameter, result and seek lifecycles becomes a single byte compare. Held strobes and a result load in the same cycle as a result read bring the edge-detection and priority cases of R11 and R12 within reach.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  // address value that selects the status/command pair
  localparam logic ADDR_CTRL = 1'b1;
  // flag positions counted down from the MSB of the status byte
  localparam int OFS_BUSY  = 1;
  localparam int OFS_CFULL = 2;
  localparam int OFS_PFULL = 3;
  localparam int OFS_RFULL = 4;
  localparam int OFS_IRQ   = 5;

  typedef struct packed {
    logic busy;
    logic cfull;
    logic pfull;
    logic rfull;
    logic irq;
  } hcr_flags_t;
endpackage

// File: rtl/hcr_decode.sv
module hcr_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic addr,
  input  logic rd,
  input  logic wr,
  output logic cmd_wr_evt,
  output logic prm_wr_evt,
  output logic res_rd_evt
);
  import hcr_pkg::*;

  logic rd_act, wr_act, rd_prev, wr_prev, rd_edge, wr_edge;

  assign rd_act  = sel & rd;
  assign wr_act  = sel & wr;
  assign rd_edge = rd_act & ~rd_prev;
  assign wr_edge = wr_act & ~wr_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_prev <= 1'b0;
      wr_prev <= 1'b0;
    end else begin
      rd_prev <= rd_act;
      wr_prev <= wr_act;
    end
  end

  assign cmd_wr_evt = wr_edge & (addr == ADDR_CTRL);
  assign prm_wr_evt = wr_edge & (addr != ADDR_CTRL);
  assign res_rd_evt = rd_edge & (addr != ADDR_CTRL);

  // a held read strobe yields a single event
  assert_one_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_rd_evt && rd_act |=> !res_rd_evt);
endmodule

// File: rtl/hcr_flags.sv
module hcr_flags (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr_evt,
  input  logic                prm_wr_evt,
  input  logic                res_rd_evt,
  input  logic                cmd_pop,
  input  logic                prm_pop,
  input  logic                res_load,
  input  logic                seek_start,
  output hcr_pkg::hcr_flags_t flags,
  output logic                cmd_accept,
  output logic                prm_accept,
  output logic                proto_err
);
  import hcr_pkg::*;

  hcr_flags_t f_q;
  logic       err_q;

  assign cmd_accept = cmd_wr_evt & ~f_q.busy;
  assign prm_accept = prm_wr_evt & ~f_q.pfull;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_q   <= '0;
      err_q <= 1'b0;
    end else begin
      if (cmd_accept)                    f_q.busy <= 1'b1;
      else if (res_rd_evt || seek_start) f_q.busy <= 1'b0;

      if (cmd_accept)   f_q.cfull <= 1'b1;
      else if (cmd_pop) f_q.cfull <= 1'b0;

      if (prm_accept)   f_q.pfull <= 1'b1;
      else if (prm_pop) f_q.pfull <= 1'b0;

      // a new result takes priority over a clearing read
      if (res_load)        f_q.rfull <= 1'b1;
      else if (res_rd_evt) f_q.rfull <= 1'b0;

      if (res_load)        f_q.irq <= 1'b1;
      else if (res_rd_evt) f_q.irq <= 1'b0;

      if (cmd_wr_evt && f_q.busy) err_q <= 1'b1;
    end
  end

  assign flags     = f_q;
  assign proto_err = err_q;

  assert_cmd_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_evt && !f_q.busy |=> f_q.busy && f_q.cfull);
  assert_busy_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_q.busy) |-> $past(cmd_wr_evt));
  assert_pop_keeps_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pop && f_q.busy && !res_rd_evt && !seek_start |=> f_q.busy && !f_q.cfull);
  assert_prm_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    f_q.pfull && !prm_pop |=> f_q.pfull);
  assert_load_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_load |=> f_q.rfull && f_q.irq);
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_rd_evt && !res_load && !cmd_wr_evt |=> !f_q.rfull && !f_q.irq && !f_q.busy);
  assert_seek_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seek_start && !cmd_wr_evt |=> !f_q.busy);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/hcr_regs.sv
module hcr_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              cmd_ld,
  input  logic              prm_ld,
  input  logic              res_ld,
  input  logic [DATA_W-1:0] res_in,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] prm_q,
  output logic [DATA_W-1:0] res_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      prm_q <= '0;
      res_q <= '0;
    end else begin
      if (cmd_ld) cmd_q <= din;
      if (prm_ld) prm_q <= din;
      if (res_ld) res_q <= res_in;
    end
  end
endmodule

// File: rtl/host_cmd_regs.sv
module host_cmd_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              irq,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_byte,
  input  logic              cmd_pop,
  output logic              prm_valid,
  output logic [DATA_W-1:0] prm_byte,
  input  logic              prm_pop,
  input  logic              res_load,
  input  logic [DATA_W-1:0] res_byte,
  input  logic              seek_start,
  output logic              busy,
  output logic              proto_err
);
  import hcr_pkg::*;

  localparam int MIN_W = OFS_IRQ;

  function automatic logic [DATA_W-1:0] pack_status(input hcr_flags_t f);
    logic [DATA_W-1:0] s;
    s = '0;
    s[DATA_W-OFS_BUSY]  = f.busy;
    s[DATA_W-OFS_CFULL] = f.cfull;
    s[DATA_W-OFS_PFULL] = f.pfull;
    s[DATA_W-OFS_RFULL] = f.rfull;
    s[DATA_W-OFS_IRQ]   = f.irq;
    return s;
  endfunction

  logic              cmd_wr_evt, prm_wr_evt, res_rd_evt;
  logic              cmd_accept, prm_accept;
  hcr_flags_t        flags;
  logic [DATA_W-1:0] res_q, status_b;

  hcr_decode u_decode (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .rd(rd), .wr(wr),
    .cmd_wr_evt(cmd_wr_evt), .prm_wr_evt(prm_wr_evt), .res_rd_evt(res_rd_evt)
  );

  hcr_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr_evt(cmd_wr_evt), .prm_wr_evt(prm_wr_evt), .res_rd_evt(res_rd_evt),
    .cmd_pop(cmd_pop), .prm_pop(prm_pop), .res_load(res_load),
    .seek_start(seek_start), .flags(flags),
    .cmd_accept(cmd_accept), .prm_accept(prm_accept), .proto_err(proto_err)
  );

  hcr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .din(din),
    .cmd_ld(cmd_accept), .prm_ld(prm_accept), .res_ld(res_load),
    .res_in(res_byte), .cmd_q(cmd_byte), .prm_q(prm_byte), .res_q(res_q)
  );

  assign status_b  = pack_status(flags);
  assign dout      = (addr == ADDR_CTRL) ? status_b : res_q;
  assign irq       = flags.irq;
  assign cmd_valid = flags.cfull;
  assign prm_valid = flags.pfull;
  assign busy      = flags.busy;

  initial assert_width_R10: assert (DATA_W >= MIN_W);

  assert_drop_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_evt && busy |=> $stable(cmd_byte));
  assert_drop_prm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prm_wr_evt && prm_valid |=> $stable(prm_byte));
endmodule

// File: tb/host_cmd_regs_bench.sv
module host_cmd_regs_bench;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, addr = 0, rd = 0, wr = 0;
  logic [W-1:0] din = '0, res_byte = '0;
  logic cmd_pop = 0, prm_pop = 0, res_load = 0, seek_start = 0;
  logic [W-1:0] dout, cmd_byte, prm_byte;
  logic irq, cmd_valid, prm_valid, busy, proto_err;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  typedef struct { string tag; logic [W-1:0] val; } item_t;
  item_t exp_q[$];
  item_t act_q[$];

  always #2.5 clk = ~clk;

  host_cmd_regs #(.DATA_W(W)) u_host_cmd_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .rd(rd), .wr(wr),
    .din(din), .dout(dout), .irq(irq), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .cmd_pop(cmd_pop), .prm_valid(prm_valid),
    .prm_byte(prm_byte), .prm_pop(prm_pop), .res_load(res_load),
    .res_byte(res_byte), .seek_start(seek_start), .busy(busy),
    .proto_err(proto_err)
  );

  // status byte as the requirements lay it out
  function automatic logic [W-1:0] st(bit b, bit cf, bit pf, bit rf, bit ir);
    return {b, cf, pf, rf, ir, 3'b000};
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pairs every sampled read with its expectation
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0) begin
      item_t a, e;
      a = act_q.pop_front();
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL %s actual=%h expected=none", a.tag, a.val);
      end else begin
        e = exp_q.pop_front();
        check(e.tag, a.val, e.val);
      end
    end
  end

  task automatic host_wr(logic a, logic [W-1:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; din = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic host_rd(logic a, string tag, logic [W-1:0] exp);
    exp_q.push_back('{tag, exp});
    @(negedge clk); sel = 1; rd = 1; addr = a;
    #1 act_q.push_back('{tag, dout});
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic pulse_cmd_pop();
    @(negedge clk); cmd_pop = 1; @(negedge clk); cmd_pop = 0;
  endtask
  task automatic pulse_prm_pop();
    @(negedge clk); prm_pop = 1; @(negedge clk); prm_pop = 0;
  endtask
  task automatic pulse_seek();
    @(negedge clk); seek_start = 1; @(negedge clk); seek_start = 0;
  endtask
  task automatic load_res(logic [W-1:0] v);
    @(negedge clk); res_load = 1; res_byte = v;
    @(negedge clk); res_load = 0;
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state, R10 layout
    host_rd(1, "R9 status after reset", 8'h00);
    host_rd(0, "R9 result after reset", 8'h00);
    #1 check("R9 irq after reset", irq, 0);
    check("R9 proto_err after reset", proto_err, 0);

    // R1, R2 command write
    host_wr(1, 8'hA5);
    host_rd(1, "R2 R10 status after command", st(1,1,0,0,0));
    #1 check("R2 cmd_byte", cmd_byte, 8'hA5);
    check("R2 cmd_valid", cmd_valid, 1);

    // R3 core takes command
    pulse_cmd_pop();
    host_rd(1, "R3 status after pop", st(1,0,0,0,0));

    // R4 parameter handshake
    host_wr(0, 8'h12);
    host_rd(1, "R4 status param full", st(1,0,1,0,0));
    #1 check("R4 prm_byte first", prm_byte, 8'h12);
    host_wr(0, 8'h34);
    #1 check("R4 prm_byte after dropped write", prm_byte, 8'h12);
    pulse_prm_pop();
    host_rd(1, "R4 status after param pop", st(1,0,0,0,0));
    host_wr(0, 8'h34);
    #1 check("R4 prm_byte second", prm_byte, 8'h34);
    pulse_prm_pop();

    // R8 command while busy
    host_wr(1, 8'h5A);
    #1 check("R8 proto_err set", proto_err, 1);
    check("R8 cmd_byte kept", cmd_byte, 8'hA5);
    host_rd(1, "R8 status unchanged", st(1,0,0,0,0));

    // R5, R6 completion
    load_res(8'h3C);
    #1 check("R5 irq high", irq, 1);
    host_rd(1, "R5 status after load", st(1,0,0,1,1));
    host_rd(0, "R1 R6 result byte", 8'h3C);
    host_rd(1, "R6 status after result read", st(0,0,0,0,0));
    #1 check("R6 irq low", irq, 0);
    check("R8 proto_err sticky", proto_err, 1);

    // R7 seek overlap
    host_wr(1, 8'h0F);
    pulse_cmd_pop();
    pulse_seek();
    host_rd(1, "R7 status after seek start", st(0,0,0,0,0));
    load_res(8'h40);
    host_rd(1, "R7 status seek complete", st(0,0,0,1,1));
    host_rd(0, "R7 seek result", 8'h40);

    // R11 held read strobe
    load_res(8'h11);
    @(negedge clk); sel = 1; rd = 1; addr = 0;
    @(negedge clk); res_load = 1; res_byte = 8'h22;
    @(negedge clk); res_load = 0;
    @(negedge clk); sel = 0; rd = 0;
    host_rd(1, "R11 second result survives held read", st(0,0,0,1,1));
    host_rd(0, "R11 second result value", 8'h22);

    // R12 load and read in one cycle
    host_wr(1, 8'h77);
    pulse_cmd_pop();
    @(negedge clk); sel = 1; rd = 1; addr = 0; res_load = 1; res_byte = 8'h99;
    @(negedge clk); sel = 0; rd = 0; res_load = 0;
    host_rd(1, "R12 load wins, busy cleared", st(0,0,0,1,1));
    host_rd(0, "R12 result value", 8'h99);

    // R9 reset mid-activity
    host_wr(1, 8'h55);
    load_res(8'hEE);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    host_rd(1, "R9 status after second reset", 8'h00);
    host_rd(0, "R9 result after second reset", 8'h00);
    #1 check("R9 proto_err cleared", proto_err, 0);
    check("R9 cmd_byte cleared", cmd_byte, 8'h00);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule